// File: doc/BRIEF.md
# Serial Auto-Baud Detector with Acknowledge

This block watches an idle serial receive line and learns the bit rate from one synchronization character sent by a host. The character is 0x7F, framed as a low start bit, eight data bits sent LSB first, an even parity bit and one high stop bit. On the wire it therefore appears as one low bit, seven high bits, one low bit (data bit 7), and then the high parity and stop bits. The block times the low start bit and the span between the falling edge of the start bit and the falling edge of data bit 7. It averages the two measurements into a divisor in clock cycles per bit.

Once the divisor is accepted, the block raises its lock flag. It waits until the sync frame has finished. It then sends the acknowledge byte 0x79 at the learned rate and opens an 8-data-bit, even-parity, one-stop-bit receiver. Received bytes are presented as one-cycle pulses, and a flag marks each byte with a parity or framing fault. The rate is learned once per reset.

The detector is a state machine with states ST_IDLE, ST_LOW, ST_HIGH, ST_TAIL, ST_ACK and ST_RUN. Its transitions are:

- ST_IDLE to ST_LOW on a falling edge.
- ST_LOW to ST_HIGH when the line rises with an in-range low time.
- ST_LOW to ST_IDLE when the low time is out of range.
- ST_HIGH to ST_TAIL on the next falling edge with an in-range average.
- ST_HIGH to ST_IDLE when the average is out of range or the span times out.
- ST_TAIL to ST_ACK after two bit times of continuous high line, which also launches the acknowledge.
- ST_ACK to ST_RUN when the transmitter goes idle.
- ST_RUN holds until reset.

The receiver has its own state machine: RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP. It moves to RX_START on a falling edge. It goes back to RX_IDLE if the line is high at mid start bit; otherwise it continues to RX_DATA. It leaves RX_DATA after eight bits, steps through RX_PAR and RX_STOP, and returns to RX_IDLE.

Top module: `autobaud_link`

## Requirements
- R1: After reset, locked_o is 0, divisor_o is 0, tx_o is 1 and no rx_valid_o, rx_par_err_o or rx_frm_err_o pulse occurs.
- R2: Let L be the cycles the start bit is low, and S the cycles from the start-bit falling edge to the data-bit-7 falling edge. The learned divisor is (8*L + S + 8) >> 4; for an undistorted 0x7F at T cycles per bit it equals T.
- R3: A low time L below MIN_BIT or above MAX_BIT, an average outside MIN_BIT..MAX_BIT, or a span S beyond 9*MAX_BIT is discarded. locked_o stays 0 and detection restarts at the next falling edge.
- R4: After lock, once the line has been high for two divisor periods after data bit 7, tx_o sends 0x79. The frame is a 0 start bit, then data LSB first, then the even parity bit (1 for 0x79), then a 1 stop bit, each bit lasting divisor_o cycles.
- R5: locked_o stays 1 and divisor_o stays unchanged until reset, including when further 0x7F bytes arrive.
- R6: Line activity before the acknowledge completes, including the sync character itself, produces no rx_valid_o pulse.
- R7: After the acknowledge, a frame is sampled at mid-bit using divisor_o. A frame with correct parity and a high stop bit gives a one-cycle rx_valid_o with the byte on rx_data_o.
- R8: A frame whose parity bit differs from the XOR of its data bits gives a one-cycle rx_par_err_o and no rx_valid_o.
- R9: A frame whose stop bit is sampled low gives a one-cycle rx_frm_err_o and no rx_valid_o.
- R10: tx_o is 1 whenever no acknowledge is being sent, including while bytes are being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Raw serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |
| locked_o | output | 1 | Rate learned; held until reset |
| divisor_o | output | DIV_W | Learned clock cycles per bit |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle pulse for a good byte |
| rx_par_err_o | output | 1 | One-cycle pulse for a parity fault |
| rx_frm_err_o | output | 1 | One-cycle pulse for a low stop bit |

## Verification
The assertions assume the following about the host:

- It idles the line high through reset.
- It sends the sync with edges whose spacing is no shorter than MIN_BIT.
- It waits for the acknowledge before sending data.
- It sends data at the learned divisor, so the receiver is never opened mid-frame.

The stimulus respects these limits. Bit times are drawn between 16 and 120 cycles, and a start-bit distortion of at most three cycles is applied so the averaged divisor stays in range. Every data byte is sent only after the acknowledge has been decoded, at the divisor the bench predicts. The out-of-range cases are a 3-cycle glitch, a low pulse longer than MAX_BIT, and a bit time one cycle below MIN_BIT. Each is followed by either a reset or a clean sync.

// File: rtl/abl_pkg.sv
package abl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_ACK,
        ST_RUN
    } det_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_t;

    localparam logic [7:0] ACK_BYTE = 8'h79;

endpackage

// File: rtl/abl_tx.sv
module abl_tx #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             start_i,
    input  logic [7:0]       data_i,
    output logic             txd_o,
    output logic             busy_o
);
    localparam int FRAME_W = 11;

    logic [FRAME_W-1:0] sh_q;
    logic [DIV_W-1:0]   cnt_q;
    logic [3:0]         bitn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '1;
            cnt_q  <= '0;
            bitn_q <= '0;
            busy_o <= 1'b0;
        end else if (start_i) begin
            sh_q   <= {1'b1, ^data_i, data_i, 1'b0};
            cnt_q  <= '0;
            bitn_q <= '0;
            busy_o <= 1'b1;
        end else if (busy_o) begin
            if (cnt_q == div_i - DIV_W'(1)) begin
                cnt_q <= '0;
                sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
                if (bitn_q == 4'(FRAME_W - 1)) begin
                    busy_o <= 1'b0;
                end else begin
                    bitn_q <= bitn_q + 4'd1;
                end
            end else begin
                cnt_q <= cnt_q + DIV_W'(1);
            end
        end
    end

    always_comb begin
        txd_o = busy_o ? sh_q[0] : 1'b1;
    end

    AST_TX_START_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);  // R4

endmodule

// File: rtl/abl_rx.sv
module abl_rx
    import abl_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             line_i,
    input  logic             fall_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [7:0]       data_o,
    output logic             valid_o,
    output logic             perr_o,
    output logic             ferr_o
);
    rx_state_t        st_q;
    logic [DIV_W-1:0] cnt_q;
    logic [2:0]       bitn_q;
    logic [7:0]       sh_q;
    logic             par_q;
    logic             bit_end;
    logic [DIV_W-1:0] half_m1;

    always_comb begin
        bit_end = (cnt_q == div_i - DIV_W'(1));
        half_m1 = (div_i >> 1) - DIV_W'(1);
        data_o  = sh_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= RX_IDLE;
            cnt_q   <= '0;
            bitn_q  <= '0;
            sh_q    <= '0;
            par_q   <= 1'b0;
            valid_o <= 1'b0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
            unique case (st_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    if (en_i && fall_i) st_q <= RX_START;
                end
                RX_START: begin
                    if (cnt_q == half_m1) begin
                        cnt_q  <= '0;
                        bitn_q <= '0;
                        st_q   <= line_i ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + DIV_W'(1);
                    end
                end
                RX_DATA: begin
                    if (bit_end) begin
                        cnt_q <= '0;
                        sh_q  <= {line_i, sh_q[7:1]};
                        if (bitn_q == 3'd7) st_q <= RX_PAR;
                        else bitn_q <= bitn_q + 3'd1;
                    end else begin
                        cnt_q <= cnt_q + DIV_W'(1);
                    end
                end
                RX_PAR: begin
                    if (bit_end) begin
                        cnt_q <= '0;
                        par_q <= line_i;
                        st_q  <= RX_STOP;
                    end else begin
                        cnt_q <= cnt_q + DIV_W'(1);
                    end
                end
                RX_STOP: begin
                    if (bit_end) begin
                        cnt_q   <= '0;
                        st_q    <= RX_IDLE;
                        ferr_o  <= !line_i;
                        perr_o  <= (par_q != ^sh_q);
                        valid_o <= line_i && (par_q == ^sh_q);
                    end else begin
                        cnt_q <= cnt_q + DIV_W'(1);
                    end
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    AST_RX_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!perr_o && !ferr_o));  // R8

endmodule

// File: rtl/autobaud_link.sv
module autobaud_link
    import abl_pkg::*;
#(
    parameter int DIV_W   = 12,
    parameter int MIN_BIT = 8,
    parameter int MAX_BIT = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    output logic             tx_o,
    output logic             locked_o,
    output logic [DIV_W-1:0] divisor_o,
    output logic [7:0]       rx_data_o,
    output logic             rx_valid_o,
    output logic             rx_par_err_o,
    output logic             rx_frm_err_o
);
    localparam int SPAN_MAX = 9 * MAX_BIT;
    localparam int LOW_W    = $clog2(MAX_BIT + 2);
    localparam int SPAN_W   = $clog2(SPAN_MAX + 2);
    localparam int AVG_W    = SPAN_W + 2;
    localparam logic [LOW_W-1:0]  MIN_L  = LOW_W'(MIN_BIT);
    localparam logic [LOW_W-1:0]  MAX_L  = LOW_W'(MAX_BIT);
    localparam logic [SPAN_W-1:0] SPAN_L = SPAN_W'(SPAN_MAX);

    det_state_t        state_q, state_d;
    logic [1:0]        sync_q;
    logic              rx_s, rx_q, fall;
    logic [LOW_W-1:0]  low_q;
    logic [SPAN_W-1:0] span_q;
    logic [DIV_W:0]    tail_q;
    logic [DIV_W-1:0]  div_q;
    logic              locked_q;
    logic [AVG_W-1:0]  avg_w;
    logic              avg_ok, tail_hit;
    logic              tx_start, tx_busy, rx_en;

    always_comb begin
        rx_s     = sync_q[1];
        fall     = rx_q & ~rx_s;
        avg_w    = ((AVG_W'(low_q) << 3) + AVG_W'(span_q) + AVG_W'(8)) >> 4;
        avg_ok   = (avg_w >= AVG_W'(MIN_BIT)) && (avg_w <= AVG_W'(MAX_BIT));
        tail_hit = (tail_q == {div_q, 1'b0} - (DIV_W + 1)'(1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fall) state_d = ST_LOW;
            ST_LOW: begin
                if (rx_s)
                    state_d = (low_q >= MIN_L && low_q <= MAX_L) ? ST_HIGH : ST_IDLE;
                else if (low_q > MAX_L)
                    state_d = ST_IDLE;
            end
            ST_HIGH: begin
                if (fall)                 state_d = avg_ok ? ST_TAIL : ST_IDLE;
                else if (span_q > SPAN_L) state_d = ST_IDLE;
            end
            ST_TAIL: if (tail_hit) state_d = ST_ACK;
            ST_ACK:  if (!tx_busy) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        tx_start = 1'b0;
        rx_en    = 1'b0;
        unique case (state_q)
            ST_TAIL: tx_start = tail_hit;
            ST_RUN:  rx_en    = 1'b1;
            default: ;
        endcase
    end

    // measurement datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= 2'b11;
            rx_q     <= 1'b1;
            low_q    <= '0;
            span_q   <= '0;
            tail_q   <= '0;
            div_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], rx_i};
            rx_q   <= rx_s;
            unique case (state_q)
                ST_IDLE: begin
                    low_q  <= LOW_W'(1);
                    span_q <= SPAN_W'(1);
                end
                ST_LOW: begin
                    span_q <= span_q + SPAN_W'(1);
                    if (!rx_s) low_q <= low_q + LOW_W'(1);
                end
                ST_HIGH: begin
                    span_q <= span_q + SPAN_W'(1);
                    tail_q <= '0;
                    if (fall && avg_ok) begin
                        div_q    <= DIV_W'(avg_w);
                        locked_q <= 1'b1;
                    end
                end
                ST_TAIL: tail_q <= rx_s ? tail_q + (DIV_W + 1)'(1) : '0;
                default: ;
            endcase
        end
    end

    abl_tx #(.DIV_W(DIV_W)) tx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_q),
        .start_i(tx_start),
        .data_i (ACK_BYTE),
        .txd_o  (tx_o),
        .busy_o (tx_busy)
    );

    abl_rx #(.DIV_W(DIV_W)) rx_i_u (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (rx_en),
        .line_i (rx_s),
        .fall_i (fall),
        .div_i  (div_q),
        .data_o (rx_data_o),
        .valid_o(rx_valid_o),
        .perr_o (rx_par_err_o),
        .ferr_o (rx_frm_err_o)
    );

    always_comb begin
        locked_o  = locked_q;
        divisor_o = div_q;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);  // R5
    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> $stable(divisor_o));  // R5
    AST_DIV_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (divisor_o >= DIV_W'(MIN_BIT) && divisor_o <= DIV_W'(MAX_BIT)));  // R3
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_o |-> tx_o);  // R10
    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> locked_o);  // R6

endmodule

// File: tb/autobaud_link_tb_top.sv
module autobaud_link_tb_top;
    localparam int DIV_W   = 12;
    localparam int MIN_BIT = 8;
    localparam int MAX_BIT = 2000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx = 1'b1;
    logic             tx_o, locked_o, rx_valid_o, rx_par_err_o, rx_frm_err_o;
    logic [DIV_W-1:0] divisor_o;
    logic [7:0]       rx_data_o;

    int checks = 0;
    int fails  = 0;
    int n_valid = 0, n_perr = 0, n_ferr = 0;
    int last_data = 0;
    bit done = 0;

    always #4 clk = ~clk;

    autobaud_link #(.DIV_W(DIV_W), .MIN_BIT(MIN_BIT), .MAX_BIT(MAX_BIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx_o), .locked_o(locked_o),
        .divisor_o(divisor_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
        .rx_par_err_o(rx_par_err_o), .rx_frm_err_o(rx_frm_err_o));

    always @(negedge clk) begin
        if (rx_valid_o) begin n_valid++; last_data = int'(rx_data_o); end
        if (rx_par_err_o) n_perr++;
        if (rx_frm_err_o) n_ferr++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_div(input int lo, input int t);
        return (8 * lo + 8 * t + 8) >> 4;
    endfunction

    function automatic int even_par(input logic [7:0] b);
        return int'(^b);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        rx = 1'b1;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
    endtask

    task automatic send_sync(input int lo, input int t);
        rx = 1'b0; wait_cyc(lo);
        rx = 1'b1; wait_cyc(8 * t - lo);
        rx = 1'b0; wait_cyc(t);
        rx = 1'b1;
    endtask

    task automatic send_byte(input int bt, input logic [7:0] d, input bit badp, input bit bads);
        rx = 1'b0; wait_cyc(bt);
        for (int b = 0; b < 8; b++) begin rx = d[b]; wait_cyc(bt); end
        rx = (^d) ^ badp; wait_cyc(bt);
        rx = !bads; wait_cyc(bt);
        rx = 1'b1; wait_cyc(2 * bt);
    endtask

    task automatic grab_tx(input int dv, output int dat, output int par, output int stp, output bit seen);
        seen = 0; dat = 0; par = 0; stp = 0;
        for (int i = 0; i < 8 * dv + 100 && !seen; i++) begin
            @(negedge clk);
            if (!tx_o) seen = 1;
        end
        if (seen) begin
            wait_cyc(dv / 2);
            for (int b = 0; b < 8; b++) begin
                wait_cyc(dv);
                dat = dat | (int'(tx_o) << b);
            end
            wait_cyc(dv); par = int'(tx_o);
            wait_cyc(dv); stp = int'(tx_o);
        end
    endtask

    task automatic lock_and_ack(input int lo, input int t, input string tag);
        int d, p, s, ed;
        bit seen;
        int v0;
        v0 = n_valid;
        ed = exp_div(lo, t);
        send_sync(lo, t);
        grab_tx(ed, d, p, s, seen);
        chk(seen, {tag, " R4 ack start seen"}, int'(seen), 1);
        chk(d == 8'h79, {tag, " R4 ack data"}, d, 8'h79);
        chk(p == 1, {tag, " R4 ack parity"}, p, 1);
        chk(s == 1, {tag, " R4 ack stop"}, s, 1);
        chk(locked_o == 1'b1, {tag, " R2 locked"}, int'(locked_o), 1);
        chk(int'(divisor_o) == ed, {tag, " R2 divisor"}, int'(divisor_o), ed);
        chk(n_valid == v0, {tag, " R6 sync not delivered"}, n_valid - v0, 0);
        wait_cyc(2 * ed);
    endtask

    task automatic rx_good(input int bt, input logic [7:0] d, input string tag);
        int v0;
        v0 = n_valid;
        send_byte(bt, d, 1'b0, 1'b0);
        chk(n_valid == v0 + 1, {tag, " R7 valid count"}, n_valid - v0, 1);
        chk(last_data == int'(d), {tag, " R7 data"}, last_data, int'(d));
        chk(tx_o == 1'b1, {tag, " R10 tx idle"}, int'(tx_o), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        chk(locked_o == 1'b0, "R1 locked", int'(locked_o), 0);
        chk(divisor_o == '0, "R1 divisor", int'(divisor_o), 0);
        chk(tx_o == 1'b1, "R1 tx idle", int'(tx_o), 1);
        wait_cyc(200);
        chk(n_valid + n_perr + n_ferr == 0, "R1 no rx pulses", n_valid + n_perr + n_ferr, 0);
        chk(locked_o == 1'b0, "R6 idle line ignored", int'(locked_o), 0);

        // directed nominal rate
        lock_and_ack(40, 40, "dir40");
        rx_good(40, 8'hA5, "dir40");
        rx_good(40, 8'h00, "dir40");
        begin
            int p0, f0, v0;
            p0 = n_perr; v0 = n_valid;
            send_byte(40, 8'h3C, 1'b1, 1'b0);
            chk(n_perr == p0 + 1, "R8 parity flag", n_perr - p0, 1);
            chk(n_valid == v0, "R8 no valid", n_valid - v0, 0);
            f0 = n_ferr; v0 = n_valid;
            send_byte(40, 8'hC3, 1'b0, 1'b1);
            chk(n_ferr == f0 + 1, "R9 framing flag", n_ferr - f0, 1);
            chk(n_valid == v0, "R9 no valid", n_valid - v0, 0);
        end
        rx_good(40, 8'h7F, "R5 resync byte");
        chk(int'(divisor_o) == 40, "R5 divisor kept", int'(divisor_o), 40);
        chk(locked_o == 1'b1, "R5 lock kept", int'(locked_o), 1);

        // random rates with start-bit distortion
        for (int it = 0; it < 5; it++) begin
            int t, dd, ed;
            t  = int'($urandom_range(16, 120));
            dd = int'($urandom_range(0, 6)) - 3;
            ed = exp_div(t + dd, t);
            do_reset();
            lock_and_ack(t + dd, t, "rand");
            rx_good(ed, 8'($urandom), "rand");
            rx_good(ed, 8'($urandom), "rand");
        end

        // R3 short glitch discarded
        do_reset();
        rx = 1'b0; wait_cyc(3); rx = 1'b1; wait_cyc(300);
        chk(locked_o == 1'b0, "R3 glitch rejected", int'(locked_o), 0);
        lock_and_ack(24, 24, "R3 after glitch");

        // R3 over-long low discarded
        do_reset();
        rx = 1'b0; wait_cyc(MAX_BIT + 40); rx = 1'b1; wait_cyc(100);
        chk(locked_o == 1'b0, "R3 long low rejected", int'(locked_o), 0);
        lock_and_ack(30, 30, "R3 after long low");

        // R3 boundary: one below minimum rejected, minimum accepted
        do_reset();
        send_sync(MIN_BIT - 1, MIN_BIT - 1);
        wait_cyc(300);
        chk(locked_o == 1'b0, "R3 below min", int'(locked_o), 0);
        chk(tx_o == 1'b1, "R10 no ack when unlocked", int'(tx_o), 1);
        do_reset();
        lock_and_ack(MIN_BIT, MIN_BIT, "R3 at min");
        rx_good(MIN_BIT, 8'h5A, "R3 at min");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule